// File: doc/BRIEF.md
# Incoherency Recovery Controller

This controller sits beside a block built with spatial redundancy and runs the repair when the redundant copies disagree. An incoherency pulse arrives with the identifier of the area that disagreed. The controller first asks an external scrub engine to read back the configuration data of that area and compare it. If the compare finds a difference, the controller asks for a partial rewrite of that area. A rewrite fixes configuration bits only; it cannot fix the contents of flip-flops.

If the scrub comes back clean, the fault is taken to be structural. The controller then walks through the logic cells of the area one at a time and asks an external tester to check each one. The first cell that fails is handed to an external replicator, which moves its function onto a spare cell and takes the faulty cell out of service. Either repair path ends with a "restored" status. A full pass with no failing cell ends with an "unresolved" status.

Every external request is a level held high until its acknowledge. A per-request timer stops the wait and reports a timeout. One incoherency that arrives while a recovery is in progress is held and served afterwards.

Top module: `incoh_recovery_ctrl`

## Requirements
- R1: While reset is low, and after it, every request output, `busy_o`, `done_o` and the three status outputs are 0, and `area_o` and `cell_idx_o` are 0.
- R2: An incoherency pulse seen while idle (no recovery running and none held) raises `scrub_req_o` two clock edges later, with `area_o` set to the area that came with the pulse.
- R3: If `scrub_mismatch_i` is 1 in the cycle `scrub_ack_i` is taken, `rewrite_req_o` rises on the next edge. When the rewrite is acknowledged, `done_o` pulses and `restored_o` becomes 1.
- R4: If the scrub is clean, cells are tested in rising index order from 0 to CELL_CNT-1. `cell_idx_o` starts at 0, and each acknowledge with `test_fail_i`=0 moves it up by one while `test_req_o` stays high.
- R5: A test acknowledged with `test_fail_i`=1 starts `repl_req_o` on the next edge, with `cell_idx_o` still on the failing cell, and no more cells are tested. The replication acknowledge ends the recovery with `restored_o`=1.
- R6: If cell CELL_CNT-1 passes, the recovery ends with `unresolved_o`=1 and `restored_o`=0.
- R7: An incoherency pulse that arrives during a recovery is held and served as the next recovery, using its own area. While one event is already held, later pulses are dropped.
- R8: If a request is not acknowledged within TMO_CYCLES cycles of rising, it drops, `done_o` pulses, and `timeout_o` becomes 1.
- R9: `done_o` is high for exactly one cycle per recovery, with exactly one of `restored_o`, `unresolved_o` and `timeout_o` set. That status holds until the next recovery starts, which clears it.
- R10: At most one request is high at a time, and a request stays high until it is acknowledged or times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| incoh_i | input | 1 | Incoherency event pulse |
| incoh_area_i | input | AREA_W | Area identifier sent with the event |
| busy_o | output | 1 | A recovery is in progress |
| area_o | output | AREA_W | Area under recovery, used by every request |
| scrub_req_o | output | 1 | Request a readback-and-compare scrub |
| scrub_ack_i | input | 1 | Scrub finished |
| scrub_mismatch_i | input | 1 | Scrub found a configuration difference (valid with ack) |
| rewrite_req_o | output | 1 | Request a partial rewrite of the area |
| rewrite_ack_i | input | 1 | Rewrite finished |
| test_req_o | output | 1 | Request a structural test of cell `cell_idx_o` |
| cell_idx_o | output | CIDX_W | Cell under test or being replicated |
| test_ack_i | input | 1 | Test finished |
| test_fail_i | input | 1 | Cell failed its test (valid with ack) |
| repl_req_o | output | 1 | Request replication and retirement of cell `cell_idx_o` |
| repl_ack_i | input | 1 | Replication finished |
| done_o | output | 1 | One-cycle end-of-recovery pulse |
| restored_o | output | 1 | Last recovery restored redundancy |
| unresolved_o | output | 1 | Last recovery found no faulty cell |
| timeout_o | output | 1 | Last recovery stopped on an acknowledge timeout |

## Verification
A scrub request is due two edges after an incoherency pulse taken while idle. Each later request, and each step of the cell index, is due one edge after the acknowledge that causes it. `done_o` is due one edge after the final acknowledge, or TMO_CYCLES edges after a request rose with no answer. The bench keeps a behavioural model that moves forward on each rising edge using the same inputs as the design. Every output is compared with that model at the falling edge, when all registered values have settled and no input is changing. Targeted checks in the stimulus tasks confirm the area, the cell index and the status bits at the moments the requirements name.

// File: rtl/irc_pkg.sv
package irc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SCRUB   = 3'd1,
    ST_REWRITE = 3'd2,
    ST_TEST    = 3'd3,
    ST_REPL    = 3'd4,
    ST_DONE    = 3'd5
  } irc_state_e;

  typedef struct packed {
    logic restored;
    logic unresolved;
    logic timed_out;
  } irc_status_t;
endpackage

// File: rtl/irc_event_latch.sv
module irc_event_latch #(
  parameter int AREA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic [AREA_W-1:0] evt_area_i,
  input  logic              take_i,
  output logic              pend_o,
  output logic [AREA_W-1:0] area_o
);
  logic              pend_q, pend_d;
  logic [AREA_W-1:0] area_q, area_d;

  always_comb begin
    pend_d = pend_q;
    area_d = area_q;
    if (take_i) pend_d = 1'b0;
    // slot is free, or being emptied this cycle: capture the new event
    if (evt_i && (!pend_q || take_i)) begin
      pend_d = 1'b1;
      area_d = evt_area_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      area_q <= '0;
    end else begin
      pend_q <= pend_d;
      area_q <= area_d;
    end
  end

  assign pend_o = pend_q;
  assign area_o = area_q;

  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take_i) |=> (pend_q && $stable(area_q))) else $error("held event lost"); // R7
endmodule

// File: rtl/irc_watchdog.sv
module irc_watchdog #(
  parameter int TMO_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_i,
  input  logic ack_i,
  output logic expire_o
);
  localparam int WD_W = $clog2(TMO_CYCLES + 1);
  localparam logic [WD_W-1:0] LIM_M1 = WD_W'(TMO_CYCLES - 1);

  logic [WD_W-1:0] cnt_q, cnt_d;
  logic            run;

  assign run      = wait_i && !ack_i;
  assign expire_o = run && (cnt_q == LIM_M1);

  always_comb begin
    if (run && !expire_o) cnt_d = cnt_q + 1'b1;
    else                  cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM_M1) else $error("timer overran"); // R8
endmodule

// File: rtl/irc_cell_cursor.sv
module irc_cell_cursor #(
  parameter int CELL_CNT = 8,
  parameter int CIDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [CIDX_W-1:0] idx_o,
  output logic              last_o
);
  localparam logic [CIDX_W-1:0] LAST_IDX = CIDX_W'(CELL_CNT - 1);

  logic [CIDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (clr_i)       idx_d = '0;
    else if (step_i) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == LAST_IDX);

  AST_NO_STEP_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i) |-> !last_o) else $error("cursor stepped past last cell"); // R4
endmodule

// File: rtl/incoh_recovery_ctrl.sv
module incoh_recovery_ctrl
  import irc_pkg::*;
#(
  parameter int AREA_W     = 4,
  parameter int CELL_CNT   = 8,
  parameter int TMO_CYCLES = 64,
  localparam int CIDX_W    = (CELL_CNT > 1) ? $clog2(CELL_CNT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              incoh_i,
  input  logic [AREA_W-1:0] incoh_area_i,
  output logic              busy_o,
  output logic [AREA_W-1:0] area_o,
  output logic              scrub_req_o,
  input  logic              scrub_ack_i,
  input  logic              scrub_mismatch_i,
  output logic              rewrite_req_o,
  input  logic              rewrite_ack_i,
  output logic              test_req_o,
  output logic [CIDX_W-1:0] cell_idx_o,
  input  logic              test_ack_i,
  input  logic              test_fail_i,
  output logic              repl_req_o,
  input  logic              repl_ack_i,
  output logic              done_o,
  output logic              restored_o,
  output logic              unresolved_o,
  output logic              timeout_o
);
  irc_state_e        state_q, state_d;
  irc_status_t       stat_q, stat_d;
  logic [AREA_W-1:0] area_q, area_d;

  logic              pend, take;
  logic [AREA_W-1:0] pend_area;
  logic              waiting, ack_sel, expire;
  logic              cur_clr, cur_step, cur_last;

  irc_event_latch #(.AREA_W(AREA_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt_i(incoh_i), .evt_area_i(incoh_area_i),
    .take_i(take), .pend_o(pend), .area_o(pend_area)
  );

  irc_watchdog #(.TMO_CYCLES(TMO_CYCLES)) u_wd (
    .clk(clk), .rst_n(rst_n), .wait_i(waiting), .ack_i(ack_sel), .expire_o(expire)
  );

  irc_cell_cursor #(.CELL_CNT(CELL_CNT), .CIDX_W(CIDX_W)) u_cur (
    .clk(clk), .rst_n(rst_n), .clr_i(cur_clr), .step_i(cur_step),
    .idx_o(cell_idx_o), .last_o(cur_last)
  );

  // acknowledge that belongs to the request currently raised
  always_comb begin
    waiting = 1'b1;
    ack_sel = 1'b0;
    case (state_q)
      ST_SCRUB:   ack_sel = scrub_ack_i;
      ST_REWRITE: ack_sel = rewrite_ack_i;
      ST_TEST:    ack_sel = test_ack_i;
      ST_REPL:    ack_sel = repl_ack_i;
      default:    waiting = 1'b0;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    stat_d   = stat_q;
    area_d   = area_q;
    take     = 1'b0;
    cur_clr  = 1'b0;
    cur_step = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (pend) begin
          take    = 1'b1;
          area_d  = pend_area;
          cur_clr = 1'b1;
          stat_d  = '0;
          state_d = ST_SCRUB;
        end
      end
      ST_SCRUB: begin
        if (scrub_ack_i) begin
          state_d = scrub_mismatch_i ? ST_REWRITE : ST_TEST;
        end else if (expire) begin
          stat_d.timed_out = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_REWRITE: begin
        if (rewrite_ack_i) begin
          stat_d.restored = 1'b1;
          state_d = ST_DONE;
        end else if (expire) begin
          stat_d.timed_out = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_TEST: begin
        if (test_ack_i) begin
          if (test_fail_i) begin
            state_d = ST_REPL;
          end else if (cur_last) begin
            stat_d.unresolved = 1'b1;
            state_d = ST_DONE;
          end else begin
            cur_step = 1'b1;
          end
        end else if (expire) begin
          stat_d.timed_out = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_REPL: begin
        if (repl_ack_i) begin
          stat_d.restored = 1'b1;
          state_d = ST_DONE;
        end else if (expire) begin
          stat_d.timed_out = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stat_q  <= '0;
      area_q  <= '0;
    end else begin
      state_q <= state_d;
      stat_q  <= stat_d;
      area_q  <= area_d;
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign area_o        = area_q;
  assign scrub_req_o   = (state_q == ST_SCRUB);
  assign rewrite_req_o = (state_q == ST_REWRITE);
  assign test_req_o    = (state_q == ST_TEST);
  assign repl_req_o    = (state_q == ST_REPL);
  assign done_o        = (state_q == ST_DONE);
  assign restored_o    = stat_q.restored;
  assign unresolved_o  = stat_q.unresolved;
  assign timeout_o     = stat_q.timed_out;

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scrub_req_o, rewrite_req_o, test_req_o, repl_req_o})) else $error("two requests"); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !ack_sel && !expire) |=> (state_q == $past(state_q))) else $error("request dropped"); // R10
  AST_TMO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && expire && !ack_sel) |=> (done_o && timeout_o)) else $error("timeout not reported"); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o) else $error("done longer than one cycle"); // R9
  AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones({restored_o, unresolved_o, timeout_o}) == 1)) else $error("bad status"); // R9
  AST_REPL_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req_o && test_ack_i && test_fail_i) |=> (repl_req_o && $stable(cell_idx_o))) else $error("replication missed"); // R5
endmodule

// File: tb/incoh_recovery_ctrl_tb.sv
`timescale 1ns/1ps
module incoh_recovery_ctrl_tb;
  localparam int AREA_W = 4;
  localparam int CELLS  = 4;
  localparam int TMO    = 12;
  localparam int CW     = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic incoh_i; logic [AREA_W-1:0] incoh_area_i;
  logic busy_o; logic [AREA_W-1:0] area_o;
  logic scrub_req_o, scrub_ack_i, scrub_mismatch_i;
  logic rewrite_req_o, rewrite_ack_i;
  logic test_req_o, test_ack_i, test_fail_i; logic [CW-1:0] cell_idx_o;
  logic repl_req_o, repl_ack_i;
  logic done_o, restored_o, unresolved_o, timeout_o;

  incoh_recovery_ctrl #(.AREA_W(AREA_W), .CELL_CNT(CELLS), .TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .incoh_i(incoh_i), .incoh_area_i(incoh_area_i),
    .busy_o(busy_o), .area_o(area_o),
    .scrub_req_o(scrub_req_o), .scrub_ack_i(scrub_ack_i), .scrub_mismatch_i(scrub_mismatch_i),
    .rewrite_req_o(rewrite_req_o), .rewrite_ack_i(rewrite_ack_i),
    .test_req_o(test_req_o), .cell_idx_o(cell_idx_o), .test_ack_i(test_ack_i), .test_fail_i(test_fail_i),
    .repl_req_o(repl_req_o), .repl_ack_i(repl_ack_i),
    .done_o(done_o), .restored_o(restored_o), .unresolved_o(unresolved_o), .timeout_o(timeout_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit run_cmp = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural model: phase 0 idle, 1 scrub, 2 rewrite, 3 test, 4 replicate, 5 finish
  int m_pend, m_parea, m_ph, m_area, m_cell, m_wd, m_rest, m_unres, m_tmo;
  int t_wait, t_ack, t_wd, t_pend, t_parea, t_take;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_parea = 0; m_ph = 0; m_area = 0; m_cell = 0; m_wd = 0;
      m_rest = 0; m_unres = 0; m_tmo = 0;
    end else begin
      t_take = (m_ph == 0 && m_pend != 0);
      t_pend = t_take ? 0 : m_pend; t_parea = m_parea;
      if (incoh_i && (m_pend == 0 || t_take)) begin t_pend = 1; t_parea = incoh_area_i; end
      t_wait = (m_ph >= 1 && m_ph <= 4);
      t_ack  = (m_ph == 1) ? scrub_ack_i : (m_ph == 2) ? rewrite_ack_i :
               (m_ph == 3) ? test_ack_i : (m_ph == 4) ? repl_ack_i : 0;
      t_wd   = (t_wait && !t_ack && m_wd != TMO - 1) ? m_wd + 1 : 0;
      if (m_ph == 0) begin
        if (m_pend != 0) begin
          m_ph = 1; m_area = m_parea; m_cell = 0; m_rest = 0; m_unres = 0; m_tmo = 0;
        end
      end else if (m_ph == 5) begin
        m_ph = 0;
      end else if (t_ack) begin
        case (m_ph)
          1: m_ph = scrub_mismatch_i ? 2 : 3;
          2: begin m_rest = 1; m_ph = 5; end
          3: if (test_fail_i) m_ph = 4;
             else if (m_cell == CELLS - 1) begin m_unres = 1; m_ph = 5; end
             else m_cell = m_cell + 1;
          default: begin m_rest = 1; m_ph = 5; end
        endcase
      end else if (m_wd == TMO - 1) begin
        m_tmo = 1; m_ph = 5;
      end
      m_wd = t_wd; m_pend = t_pend; m_parea = t_parea;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog expired actual=%0d expected<=20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (run_cmp) begin
      chk("R2", "busy_o", busy_o, m_ph != 0);
      chk("R2", "area_o", area_o, m_area);
      chk("R2", "scrub_req_o", scrub_req_o, m_ph == 1);
      chk("R3", "rewrite_req_o", rewrite_req_o, m_ph == 2);
      chk("R4", "test_req_o", test_req_o, m_ph == 3);
      chk("R4", "cell_idx_o", cell_idx_o, m_cell);
      chk("R5", "repl_req_o", repl_req_o, m_ph == 4);
      chk("R9", "done_o", done_o, m_ph == 5);
      chk("R3", "restored_o", restored_o, m_rest);
      chk("R6", "unresolved_o", unresolved_o, m_unres);
      chk("R8", "timeout_o", timeout_o, m_tmo);
    end
  end

  task automatic pulse_incoh(int a);
    incoh_i = 1'b1; incoh_area_i = AREA_W'(a);
    @(negedge clk);
    incoh_i = 1'b0;
  endtask

  task automatic serve_scrub(int d, bit mm, int exp_area);
    while (!scrub_req_o) @(negedge clk);
    chk("R2", "area at scrub", area_o, exp_area);
    repeat (d) @(negedge clk);
    scrub_ack_i = 1'b1; scrub_mismatch_i = mm;
    @(negedge clk);
    scrub_ack_i = 1'b0; scrub_mismatch_i = 1'b0;
  endtask

  task automatic serve_rewrite(int d);
    while (!rewrite_req_o) @(negedge clk);
    repeat (d) @(negedge clk);
    rewrite_ack_i = 1'b1;
    @(negedge clk);
    rewrite_ack_i = 1'b0;
  endtask

  task automatic serve_test(int d, bit fail, int exp_cell);
    while (!test_req_o) @(negedge clk);
    chk("R4", "cell under test", cell_idx_o, exp_cell);
    repeat (d) @(negedge clk);
    test_ack_i = 1'b1; test_fail_i = fail;
    @(negedge clk);
    test_ack_i = 1'b0; test_fail_i = 1'b0;
  endtask

  task automatic serve_repl(int d, int exp_cell);
    while (!repl_req_o) @(negedge clk);
    chk("R5", "cell replicated", cell_idx_o, exp_cell);
    repeat (d) @(negedge clk);
    repl_ack_i = 1'b1;
    @(negedge clk);
    repl_ack_i = 1'b0;
  endtask

  task automatic wait_done(int r, int u, int t);
    while (!done_o) @(negedge clk);
    chk("R9", "restored at done", restored_o, r);
    chk("R6", "unresolved at done", unresolved_o, u);
    chk("R8", "timeout at done", timeout_o, t);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; incoh_i = 1'b0; incoh_area_i = '0;
    scrub_ack_i = 1'b0; scrub_mismatch_i = 1'b0; rewrite_ack_i = 1'b0;
    test_ack_i = 1'b0; test_fail_i = 1'b0; repl_ack_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", busy_o, 0);
    chk("R1", "reset requests", {scrub_req_o, rewrite_req_o, test_req_o, repl_req_o}, 0);
    chk("R1", "reset status", {done_o, restored_o, unresolved_o, timeout_o}, 0);
    chk("R1", "reset area/cell", {area_o, cell_idx_o}, 0);
    rst_n = 1'b1;
    run_cmp = 1;
    repeat (2) @(negedge clk);

    // R2 latency then R3 rewrite path
    pulse_incoh(5);
    chk("R2", "no scrub after one edge", scrub_req_o, 0);
    @(negedge clk);
    chk("R2", "scrub after two edges", scrub_req_o, 1);
    serve_scrub(3, 1'b1, 5);
    chk("R3", "rewrite follows mismatch", rewrite_req_o, 1);
    serve_rewrite(2);
    wait_done(1, 0, 0);
    repeat (4) @(negedge clk);
    chk("R9", "restored held", restored_o, 1);

    // R4/R5 failing cell 2
    pulse_incoh(9);
    serve_scrub(1, 1'b0, 9);
    chk("R9", "status cleared on start", restored_o, 0);
    serve_test(0, 1'b0, 0);
    serve_test(2, 1'b0, 1);
    serve_test(1, 1'b1, 2);
    serve_repl(3, 2);
    wait_done(1, 0, 0);

    // R6 all cells pass
    pulse_incoh(3);
    serve_scrub(0, 1'b0, 3);
    for (int c = 0; c < CELLS; c++) serve_test(1, 1'b0, c);
    wait_done(0, 1, 0);

    // R7 events during recovery: first held, second dropped
    pulse_incoh(7);
    while (!scrub_req_o) @(negedge clk);
    pulse_incoh(10);
    pulse_incoh(12);
    serve_scrub(2, 1'b1, 7);
    serve_rewrite(1);
    wait_done(1, 0, 0);
    serve_scrub(1, 1'b1, 10);
    chk("R7", "held area served", area_o, 10);
    serve_rewrite(0);
    wait_done(1, 0, 0);
    repeat (5) @(negedge clk);
    chk("R7", "dropped event not served", busy_o, 0);

    // R8 timeouts in scrub and in test
    pulse_incoh(1);
    wait_done(0, 0, 1);
    chk("R8", "requests dropped after timeout", {scrub_req_o, test_req_o}, 0);
    pulse_incoh(2);
    serve_scrub(0, 1'b0, 2);
    serve_test(0, 1'b0, 0);
    wait_done(0, 0, 1);

    // R8 ack on the last allowed cycle wins over the timeout
    pulse_incoh(4);
    serve_scrub(TMO - 1, 1'b1, 4);
    serve_rewrite(0);
    wait_done(1, 0, 0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule